// File: doc/BRIEF.md
# Character Display Cursor and Scroll Sequencer

This block holds the cursor position and horizontal scroll state of a character display controller. One address register serves both the visible-character memory (display RAM, 7-bit address) and the user-glyph memory (glyph RAM, 6-bit address). A select flag records which of the two memories later data transfers go to. A scroll offset records how far the visible window has been shifted along the line.

A command decoder drives the block with single-cycle strobes: clear, home, load display address, load glyph address, move (cursor or whole display), and transfer done (read or write). Level inputs carry the entry direction, the entry auto-scroll enable and the line mode. All outputs are registered, so every strobe takes effect on the clock edge that samples it. The memories themselves, the bus handshake, busy timing and pixel generation sit outside the block.

Top module: `cursor_scroll_seq`

## Requirements
- R1: While `rst_n` is low, and after its release, `ram_addr` is 0, `sel_glyph` is 0 and `scroll_ofs` is 0. Strobes that arrive during reset have no effect.
- R2: `clr_stb` sets `ram_addr` to 0, clears `sel_glyph` (display RAM) and sets `scroll_ofs` to 0 on the next edge.
- R3: `home_stb` sets `ram_addr` and `scroll_ofs` to 0 and leaves `sel_glyph` unchanged.
- R4: `load_disp_stb` loads all 7 bits of `load_addr` and clears `sel_glyph`. `load_glyph_stb` loads `load_addr[5:0]` with bit 6 forced to 0 and sets `sel_glyph`.
- R5: `xfer_stb` steps `ram_addr` by +1 when `entry_inc`=1 and by -1 when `entry_inc`=0, for both reads and writes.
- R6: Address steps wrap within 7 bits (127 and 0 are neighbours) while `sel_glyph`=0, and within 6 bits (63 and 0 are neighbours, bit 6 stays 0) while `sel_glyph`=1.
- R7: A transfer with `xfer_write`=1 and `entry_scroll`=1 also steps `scroll_ofs`: +1 when `entry_inc`=1, -1 when `entry_inc`=0. A read never changes `scroll_ofs`.
- R8: `move_stb` with `move_disp`=0 steps `ram_addr` by +1 when `move_right`=1 and by -1 when `move_right`=0, and leaves `scroll_ofs` unchanged.
- R9: `move_stb` with `move_disp`=1 steps `scroll_ofs` by -1 when `move_right`=1 and by +1 when `move_right`=0, and leaves `ram_addr` unchanged.
- R10: `scroll_ofs` wraps within 0..15 when `two_line`=0 and within 0..7 when `two_line`=1.
- R11: When several strobes coincide, only the highest-ranked one acts, in this order: clear, home, load display, load glyph, move, transfer.
- R12: In a cycle with no strobe, all three outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_stb | input | 1 | Clear command strobe |
| home_stb | input | 1 | Return-home command strobe |
| load_disp_stb | input | 1 | Load display RAM address strobe |
| load_glyph_stb | input | 1 | Load glyph RAM address strobe |
| load_addr | input | 7 | Address value for the load strobes |
| move_stb | input | 1 | Cursor or display move strobe |
| move_disp | input | 1 | 1: move the display, 0: move the cursor |
| move_right | input | 1 | 1: right, 0: left |
| xfer_stb | input | 1 | Data transfer completed strobe |
| xfer_write | input | 1 | 1: the transfer was a write |
| entry_inc | input | 1 | Entry direction, 1 increment, 0 decrement |
| entry_scroll | input | 1 | Scroll the display on writes |
| two_line | input | 1 | Line mode, 1 selects the 8-column wrap |
| ram_addr | output | 7 | Current memory address |
| sel_glyph | output | 1 | 1: glyph RAM selected, 0: display RAM |
| scroll_ofs | output | 4 | Display start offset |

## Verification
The checker watches, on every cycle, the rules that relate a single strobe to the next state: clear and home results, the 7-bit step on display transfers, a cursor move leaving the scroll offset alone, a display move leaving the address alone, the glyph address never carrying bit 6, and the hold when no strobe is present. Wrap points of both the address and the offset in both line modes, the difference between reads and writes under auto-scroll, and the strobe priority all depend on a prepared prior state. Only the bench's ordered scenarios show them, with the reset behaviour in the middle of a run.

// File: rtl/cursor_scroll_pkg.sv
package cursor_scroll_pkg;

   typedef enum logic [1:0] {
      SRC_ZERO  = 2'd0,
      SRC_DISP  = 2'd1,
      SRC_GLYPH = 2'd2
   } load_src_e;

   typedef struct packed {
      logic      addr_load;
      load_src_e addr_src;
      logic      addr_step;
      logic      addr_up;
      logic      sel_load;
      logic      sel_val;
      logic      ofs_zero;
      logic      ofs_step;
      logic      ofs_up;
   } seq_op_t;

endpackage

// File: rtl/css_cmd_decode.sv
module css_cmd_decode
   import cursor_scroll_pkg::*;
(
   input  logic    clr_stb,
   input  logic    home_stb,
   input  logic    load_disp_stb,
   input  logic    load_glyph_stb,
   input  logic    move_stb,
   input  logic    move_disp,
   input  logic    move_right,
   input  logic    xfer_stb,
   input  logic    xfer_write,
   input  logic    entry_inc,
   input  logic    entry_scroll,
   output seq_op_t op
);

   always_comb begin
      op = '0;
      op.addr_src = SRC_ZERO;
      if (clr_stb) begin
         op.addr_load = 1'b1;
         op.sel_load  = 1'b1;
         op.sel_val   = 1'b0;
         op.ofs_zero  = 1'b1;
      end else if (home_stb) begin
         op.addr_load = 1'b1;
         op.ofs_zero  = 1'b1;
      end else if (load_disp_stb) begin
         op.addr_load = 1'b1;
         op.addr_src  = SRC_DISP;
         op.sel_load  = 1'b1;
         op.sel_val   = 1'b0;
      end else if (load_glyph_stb) begin
         op.addr_load = 1'b1;
         op.addr_src  = SRC_GLYPH;
         op.sel_load  = 1'b1;
         op.sel_val   = 1'b1;
      end else if (move_stb) begin
         if (move_disp) begin
            op.ofs_step = 1'b1;
            op.ofs_up   = ~move_right;
         end else begin
            op.addr_step = 1'b1;
            op.addr_up   = move_right;
         end
      end else if (xfer_stb) begin
         op.addr_step = 1'b1;
         op.addr_up   = entry_inc;
         if (xfer_write && entry_scroll) begin
            op.ofs_step = 1'b1;
            op.ofs_up   = entry_inc;
         end
      end
   end

endmodule

// File: rtl/css_addr_ctr.sv
module css_addr_ctr
   import cursor_scroll_pkg::*;
#(
   parameter int DISP_AW  = 7,
   parameter int GLYPH_AW = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               addr_load,
   input  load_src_e          addr_src,
   input  logic               addr_step,
   input  logic               addr_up,
   input  logic               sel_load,
   input  logic               sel_val,
   input  logic [DISP_AW-1:0] load_addr,
   output logic [DISP_AW-1:0] addr_q,
   output logic               sel_q
);

   localparam int PAD_W = DISP_AW - GLYPH_AW;

   logic [DISP_AW-1:0]  disp_next;
   logic [GLYPH_AW-1:0] glyph_cur;
   logic [GLYPH_AW-1:0] glyph_next;
   logic [DISP_AW-1:0]  glyph_ext;
   logic [DISP_AW-1:0]  glyph_load;
   logic [DISP_AW-1:0]  addr_d;

   assign glyph_cur  = addr_q[GLYPH_AW-1:0];
   assign disp_next  = addr_up ? addr_q + 1'b1 : addr_q - 1'b1;
   assign glyph_next = addr_up ? glyph_cur + 1'b1 : glyph_cur - 1'b1;

   generate
      if (PAD_W == 0) begin : g_same_width
         assign glyph_ext  = glyph_next;
         assign glyph_load = load_addr;
      end else begin : g_padded
         assign glyph_ext  = {{PAD_W{1'b0}}, glyph_next};
         assign glyph_load = {{PAD_W{1'b0}}, load_addr[GLYPH_AW-1:0]};
      end
   endgenerate

   always_comb begin
      addr_d = addr_q;
      if (addr_load) begin
         case (addr_src)
            SRC_DISP:  addr_d = load_addr;
            SRC_GLYPH: addr_d = glyph_load;
            default:   addr_d = '0;
         endcase
      end else if (addr_step) begin
         addr_d = sel_q ? glyph_ext : disp_next;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         sel_q  <= 1'b0;
      end else begin
         addr_q <= addr_d;
         if (sel_load) sel_q <= sel_val;
      end
   end

endmodule

// File: rtl/css_scroll_ctr.sv
module css_scroll_ctr #(
   parameter int LEN_ONE = 16,
   parameter int LEN_TWO = 8,
   parameter int OFS_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             two_line,
   input  logic             ofs_zero,
   input  logic             ofs_step,
   input  logic             ofs_up,
   output logic [OFS_W-1:0] ofs_q
);

   localparam logic [OFS_W-1:0] LAST_ONE = OFS_W'(LEN_ONE - 1);
   localparam logic [OFS_W-1:0] LAST_TWO = OFS_W'(LEN_TWO - 1);
   localparam bool_pow2 = ((LEN_ONE & (LEN_ONE - 1)) == 0) &&
                          ((LEN_TWO & (LEN_TWO - 1)) == 0);

   logic [OFS_W-1:0] last;
   logic [OFS_W-1:0] step_next;

   assign last = two_line ? LAST_TWO : LAST_ONE;

   generate
      if (bool_pow2) begin : g_mask_wrap
         logic [OFS_W-1:0] raw;
         assign raw       = ofs_up ? ofs_q + 1'b1 : ofs_q - 1'b1;
         assign step_next = raw & last;
      end else begin : g_cmp_wrap
         always_comb begin
            if (ofs_up) step_next = (ofs_q >= last) ? '0 : ofs_q + 1'b1;
            else        step_next = (ofs_q == '0 || ofs_q > last) ? last : ofs_q - 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        ofs_q <= '0;
      else if (ofs_zero) ofs_q <= '0;
      else if (ofs_step) ofs_q <= step_next;
   end

endmodule

// File: rtl/cursor_scroll_seq.sv
module cursor_scroll_seq
   import cursor_scroll_pkg::*;
#(
   parameter int DISP_AW  = 7,
   parameter int GLYPH_AW = 6,
   parameter int LEN_ONE  = 16,
   parameter int LEN_TWO  = 8,
   parameter int OFS_W    = $clog2(LEN_ONE)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_stb,
   input  logic               home_stb,
   input  logic               load_disp_stb,
   input  logic               load_glyph_stb,
   input  logic [DISP_AW-1:0] load_addr,
   input  logic               move_stb,
   input  logic               move_disp,
   input  logic               move_right,
   input  logic               xfer_stb,
   input  logic               xfer_write,
   input  logic               entry_inc,
   input  logic               entry_scroll,
   input  logic               two_line,
   output logic [DISP_AW-1:0] ram_addr,
   output logic               sel_glyph,
   output logic [OFS_W-1:0]   scroll_ofs
);

   generate
      if (GLYPH_AW < 1 || GLYPH_AW > DISP_AW) begin : g_bad_aw
         $error("GLYPH_AW must lie in 1..DISP_AW");
      end
      if (LEN_TWO < 2 || LEN_TWO > LEN_ONE) begin : g_bad_len
         $error("LEN_TWO must lie in 2..LEN_ONE");
      end
      if ((1 << OFS_W) < LEN_ONE) begin : g_bad_ofs
         $error("OFS_W too narrow for LEN_ONE");
      end
   endgenerate

   seq_op_t op;

   css_cmd_decode u_dec (
      .clr_stb        (clr_stb),
      .home_stb       (home_stb),
      .load_disp_stb  (load_disp_stb),
      .load_glyph_stb (load_glyph_stb),
      .move_stb       (move_stb),
      .move_disp      (move_disp),
      .move_right     (move_right),
      .xfer_stb       (xfer_stb),
      .xfer_write     (xfer_write),
      .entry_inc      (entry_inc),
      .entry_scroll   (entry_scroll),
      .op             (op)
   );

   css_addr_ctr #(
      .DISP_AW  (DISP_AW),
      .GLYPH_AW (GLYPH_AW)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_load (op.addr_load),
      .addr_src  (op.addr_src),
      .addr_step (op.addr_step),
      .addr_up   (op.addr_up),
      .sel_load  (op.sel_load),
      .sel_val   (op.sel_val),
      .load_addr (load_addr),
      .addr_q    (ram_addr),
      .sel_q     (sel_glyph)
   );

   css_scroll_ctr #(
      .LEN_ONE (LEN_ONE),
      .LEN_TWO (LEN_TWO),
      .OFS_W   (OFS_W)
   ) u_scroll (
      .clk      (clk),
      .rst_n    (rst_n),
      .two_line (two_line),
      .ofs_zero (op.ofs_zero),
      .ofs_step (op.ofs_step),
      .ofs_up   (op.ofs_up),
      .ofs_q    (scroll_ofs)
   );

endmodule

// File: rtl/cursor_scroll_seq_chk.sv
module cursor_scroll_seq_chk #(
   parameter int DISP_AW  = 7,
   parameter int GLYPH_AW = 6,
   parameter int OFS_W    = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               clr_stb,
   input logic               home_stb,
   input logic               load_disp_stb,
   input logic               load_glyph_stb,
   input logic               move_stb,
   input logic               move_disp,
   input logic               xfer_stb,
   input logic               entry_inc,
   input logic [DISP_AW-1:0] ram_addr,
   input logic               sel_glyph,
   input logic [OFS_W-1:0]   scroll_ofs
);

   logic no_load;
   logic any_stb;
   assign no_load = !clr_stb && !home_stb && !load_disp_stb && !load_glyph_stb;
   assign any_stb = !no_load || move_stb || xfer_stb;

   // R2
   p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> (ram_addr == '0) && !sel_glyph && (scroll_ofs == '0));

   // R3
   p_home_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (home_stb && !clr_stb) |=> (ram_addr == '0) && (scroll_ofs == '0) && $stable(sel_glyph));

   // R5
   p_disp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (no_load && !move_stb && xfer_stb && !sel_glyph && entry_inc)
      |=> ram_addr == DISP_AW'($past(ram_addr) + 1'b1));

   // R6
   p_glyph_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sel_glyph |-> ((ram_addr >> GLYPH_AW) == '0));

   // R8
   p_cursor_keeps_ofs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (no_load && move_stb && !move_disp) |=> $stable(scroll_ofs));

   // R9
   p_scroll_keeps_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (no_load && move_stb && move_disp) |=> $stable(ram_addr) && $stable(sel_glyph));

   // R12
   p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !any_stb |=> $stable(ram_addr) && $stable(sel_glyph) && $stable(scroll_ofs));

endmodule

bind cursor_scroll_seq cursor_scroll_seq_chk #(
   .DISP_AW  (DISP_AW),
   .GLYPH_AW (GLYPH_AW),
   .OFS_W    (OFS_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .clr_stb        (clr_stb),
   .home_stb       (home_stb),
   .load_disp_stb  (load_disp_stb),
   .load_glyph_stb (load_glyph_stb),
   .move_stb       (move_stb),
   .move_disp      (move_disp),
   .xfer_stb       (xfer_stb),
   .entry_inc      (entry_inc),
   .ram_addr       (ram_addr),
   .sel_glyph      (sel_glyph),
   .scroll_ofs     (scroll_ofs)
);

// File: tb/cursor_scroll_seq_tb.sv
module cursor_scroll_seq_tb;

   localparam int VW = 55;
   localparam int NV = 32;

   // control field bit positions: clr home ldd ldg mv mvd mvr xf xw inc scr two
   localparam logic [11:0] C_CLR = 12'h800;
   localparam logic [11:0] C_HOM = 12'h400;
   localparam logic [11:0] C_LDD = 12'h200;
   localparam logic [11:0] C_LDG = 12'h100;
   localparam logic [11:0] C_MV  = 12'h080;
   localparam logic [11:0] C_MVD = 12'h040;
   localparam logic [11:0] C_MVR = 12'h020;
   localparam logic [11:0] C_XF  = 12'h010;
   localparam logic [11:0] C_XW  = 12'h008;
   localparam logic [11:0] C_INC = 12'h004;
   localparam logic [11:0] C_SCR = 12'h002;
   localparam logic [11:0] C_TWO = 12'h001;

   function automatic logic [VW-1:0] v(input logic [23:0] tag, input logic [11:0] ctl,
                                       input logic [6:0] ain, input logic [6:0] ea,
                                       input logic es, input logic [3:0] eo);
      return {tag, ctl, ain, ea, es, eo};
   endfunction

   localparam logic [VW-1:0] VEC [0:NV-1] = '{
      v("R4 ", C_LDD, 7'h7E, 7'h7E, 1'b0, 4'd0),
      v("R5 ", C_XF|C_XW|C_INC, 7'h00, 7'h7F, 1'b0, 4'd0),
      v("R6 ", C_XF|C_INC, 7'h00, 7'h00, 1'b0, 4'd0),
      v("R6 ", C_XF, 7'h00, 7'h7F, 1'b0, 4'd0),
      v("R7 ", C_XF|C_XW|C_INC|C_SCR, 7'h00, 7'h00, 1'b0, 4'd1),
      v("R7 ", C_XF|C_XW|C_SCR, 7'h00, 7'h7F, 1'b0, 4'd0),
      v("R10", C_XF|C_XW|C_SCR, 7'h00, 7'h7E, 1'b0, 4'd15),
      v("R7 ", C_XF|C_INC|C_SCR, 7'h00, 7'h7F, 1'b0, 4'd15),
      v("R9 ", C_MV|C_MVD|C_MVR, 7'h00, 7'h7F, 1'b0, 4'd14),
      v("R9 ", C_MV|C_MVD, 7'h00, 7'h7F, 1'b0, 4'd15),
      v("R10", C_MV|C_MVD, 7'h00, 7'h7F, 1'b0, 4'd0),
      v("R8 ", C_MV|C_MVR, 7'h00, 7'h00, 1'b0, 4'd0),
      v("R8 ", C_MV, 7'h00, 7'h7F, 1'b0, 4'd0),
      v("R4 ", C_LDG, 7'h7F, 7'h3F, 1'b1, 4'd0),
      v("R6 ", C_XF|C_INC, 7'h00, 7'h00, 1'b1, 4'd0),
      v("R6 ", C_XF, 7'h00, 7'h3F, 1'b1, 4'd0),
      v("R8 ", C_MV|C_MVR, 7'h00, 7'h00, 1'b1, 4'd0),
      v("R9 ", C_MV|C_MVD, 7'h00, 7'h00, 1'b1, 4'd1),
      v("R3 ", C_HOM, 7'h00, 7'h00, 1'b1, 4'd0),
      v("R4 ", C_LDD, 7'h05, 7'h05, 1'b0, 4'd0),
      v("R10", C_MV|C_MVD|C_MVR|C_TWO, 7'h00, 7'h05, 1'b0, 4'd7),
      v("R10", C_MV|C_MVD|C_TWO, 7'h00, 7'h05, 1'b0, 4'd0),
      v("R7 ", C_XF|C_XW|C_INC|C_SCR|C_TWO, 7'h00, 7'h06, 1'b0, 4'd1),
      v("R12", 12'h000, 7'h55, 7'h06, 1'b0, 4'd1),
      v("R11", C_CLR|C_HOM|C_LDD|C_XF, 7'h33, 7'h00, 1'b0, 4'd0),
      v("R11", C_LDD|C_LDG|C_XF, 7'h45, 7'h45, 1'b0, 4'd0),
      v("R4 ", C_LDG, 7'h12, 7'h12, 1'b1, 4'd0),
      v("R11", C_MV|C_MVD|C_XF|C_INC, 7'h00, 7'h12, 1'b1, 4'd1),
      v("R11", C_HOM|C_MV|C_XF, 7'h00, 7'h00, 1'b1, 4'd0),
      v("R5 ", C_XF|C_INC, 7'h00, 7'h01, 1'b1, 4'd0),
      v("R9 ", C_MV|C_MVD, 7'h00, 7'h01, 1'b1, 4'd1),
      v("R2 ", C_CLR, 7'h00, 7'h00, 1'b0, 4'd0)
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr_stb, home_stb, load_disp_stb, load_glyph_stb;
   logic [6:0] load_addr;
   logic move_stb, move_disp, move_right;
   logic xfer_stb, xfer_write, entry_inc, entry_scroll, two_line;
   logic [6:0] ram_addr;
   logic sel_glyph;
   logic [3:0] scroll_ofs;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cursor_scroll_seq u_dut (
      .clk(clk), .rst_n(rst_n),
      .clr_stb(clr_stb), .home_stb(home_stb),
      .load_disp_stb(load_disp_stb), .load_glyph_stb(load_glyph_stb),
      .load_addr(load_addr),
      .move_stb(move_stb), .move_disp(move_disp), .move_right(move_right),
      .xfer_stb(xfer_stb), .xfer_write(xfer_write),
      .entry_inc(entry_inc), .entry_scroll(entry_scroll), .two_line(two_line),
      .ram_addr(ram_addr), .sel_glyph(sel_glyph), .scroll_ofs(scroll_ofs)
   );

   task automatic drive(input logic [11:0] c, input logic [6:0] a);
      {clr_stb, home_stb, load_disp_stb, load_glyph_stb, move_stb, move_disp,
       move_right, xfer_stb, xfer_write, entry_inc, entry_scroll, two_line} = c;
      load_addr = a;
   endtask

   task automatic check(input string req, input logic [6:0] ea, input logic es,
                        input logic [3:0] eo);
      checks++;
      if (ram_addr !== ea || sel_glyph !== es || scroll_ofs !== eo) begin
         errors++;
         $display("FAIL %s: addr=%h sel=%b ofs=%0d expected addr=%h sel=%b ofs=%0d",
                  req, ram_addr, sel_glyph, scroll_ofs, ea, es, eo);
      end
   endtask

   initial begin
      drive(12'h000, 7'h00);
      repeat (3) @(posedge clk);
      #1 check("R1 reset", 7'h00, 1'b0, 4'd0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1 check("R1 after release", 7'h00, 1'b0, 4'd0);

      // table walk: each vector acts on the state left by the previous one
      for (int i = 0; i < NV; i++) begin
         @(negedge clk) drive(VEC[i][30:19], VEC[i][18:12]);
         @(posedge clk); #1;
         check(string'(VEC[i][54:31]), VEC[i][11:5], VEC[i][4], VEC[i][3:0]);
      end

      // R1: reset in mid-run, with strobes present, returns to the reset state
      @(negedge clk) drive(C_LDG, 7'h2A);
      @(posedge clk); #1 check("R4 glyph load", 7'h2A, 1'b1, 4'd0);
      @(negedge clk) begin drive(C_MV|C_MVD, 7'h00); end
      @(posedge clk); #1 check("R9 pre-reset", 7'h2A, 1'b1, 4'd1);
      @(negedge clk) begin rst_n = 1'b0; drive(C_LDD|C_XF|C_INC, 7'h11); end
      @(posedge clk); #1 check("R1 mid-run reset", 7'h00, 1'b0, 4'd0);
      @(posedge clk); #1 check("R1 strobes ignored in reset", 7'h00, 1'b0, 4'd0);
      @(negedge clk) begin rst_n = 1'b1; drive(12'h000, 7'h00); end
      @(posedge clk); #1 check("R12 idle after reset", 7'h00, 1'b0, 4'd0);

      // R10: offset at 15 in one-line mode, display move left wraps to 0
      @(negedge clk) drive(C_MV|C_MVD|C_MVR, 7'h00);
      @(posedge clk); #1 check("R10 wrap to 15", 7'h00, 1'b0, 4'd15);
      @(negedge clk) drive(C_MV|C_MVD, 7'h00);
      @(posedge clk); #1 check("R10 wrap to 0", 7'h00, 1'b0, 4'd0);

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule